// File: doc/BRIEF.md
# Trap entry and return unit

This unit owns the hart's current privilege level and the two-level interrupt-enable stack of the status word. It serves two operations. A trap request carries a cause word, an exception PC and an optional faulting address. The unit decides whether machine or supervisor mode handles the trap. It then produces the handler PC and raises write strobes for the handling mode's cause, exception-PC and bad-address registers. A return request restores the privilege level and interrupt enable that were stacked on entry, and produces the return PC. The delegation masks, the supervisor trap vector and the two saved exception PCs arrive as inputs. The machine trap base is a parameter.

Every request is registered. The unit answers one cycle later with a single-cycle `done` pulse, or with `ret_fault` for a return refused in user mode. The privilege and status registers change on the same clock edge, so they read as updated while the pulse is high. Requests may arrive on back-to-back cycles. Each new request sees the privilege left by the one before it.

The sequencer has five named states. Every clock edge loads the next state from the inputs seen on that edge:
- IDLE is the state with nothing to report.
- ENTER_S reports a supervisor entry.
- ENTER_M reports a machine entry.
- LEAVE reports a legal return.
- REFUSE reports a return attempted in user mode.

The transitions are:
- **take_s**: a trap request whose routing selects supervisor mode goes to ENTER_S.
- **take_m**: any other trap request goes to ENTER_M.
- **resume**: a return request without a trap, made at privilege S or M, goes to LEAVE.
- **deny**: a return request without a trap, made at privilege U, goes to REFUSE.
- **rest**: no request goes to IDLE.

Top module: `trap_unit`

## Requirements
- R1: After reset the privilege output is M (U=0, S=1, M=3), the status word is all zero, and `done`, `ret_fault` and every write strobe are low.
- R2: A trap is handled in supervisor mode only when all three of these hold:
  - the current privilege is U or S;
  - the code (the cause word without its top bit) is below XLEN;
  - the delegation bit at that code is set, read from `int_deleg` when the cause's top bit is 1 and from `exc_deleg` when it is 0.

  Every other trap is handled in machine mode.
- R3: On a supervisor entry:
  - `next_pc` equals `s_vec`, and `s_ctx_we` pulses with the cause and the exception PC.
  - `s_bad_we` pulses only when `trap_has_bad` was set.
  - s_pie takes the enable bit of the mode that was interrupted, and s_pp takes 1 when that mode was S and 0 when it was U.
  - s_ie clears and the privilege becomes S.
- R4: On a machine entry:
  - `next_pc` equals M_VEC_BASE + 64 × (the old privilege value), and `m_ctx_we` pulses.
  - `m_bad_we` pulses only when a bad address was supplied.
  - m_pie takes the old mode's enable bit and m_pp takes the old privilege.
  - m_ie clears and the privilege becomes M.
- R5: A return at privilege S:
  - yields `next_pc` = `s_epc_in`;
  - sets the enable bit of the mode named by s_pp (0 names U, 1 names S) to s_pie;
  - then clears s_pie, moves the privilege to that mode and resets s_pp to 0.
- R6: A return at privilege M:
  - yields `next_pc` = `m_epc_in`;
  - sets the enable bit of the mode named by m_pp to m_pie;
  - then clears m_pie, moves the privilege to that mode and resets m_pp to U (0).
- R7: A return at privilege U gives a one-cycle `ret_fault`. It gives no `done`, and the privilege and status are left unchanged.
- R8: Results appear in the cycle after the request as a single-cycle `done`, and at most one of `s_ctx_we`, `m_ctx_we` and `ret_fault` is high at a time. The privilege and status registers are already updated in that same cycle.
- R9: A trap and a return in the same cycle are treated as the trap alone, and the return is dropped.
- R10: When `stat_we` is high and there is no trap or return request in that cycle, the status word loads `stat_wdata`, with this layout:
  - bit 0 u_ie, bit 1 s_ie, bit 2 m_ie;
  - bit 3 u_pie, bit 4 s_pie, bit 5 m_pie;
  - bit 6 s_pp;
  - bits 8:7 m_pp.

  A written m_pp of 2 is rejected, and the old m_pp is kept. A write in the same cycle as a trap or return request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_req | input | 1 | Trap request |
| trap_cause | input | XLEN | Cause word; top bit set marks an interrupt |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_has_bad | input | 1 | The trap carries a faulting address |
| trap_bad | input | XLEN | Faulting address |
| ret_req | input | 1 | Return request |
| stat_we | input | 1 | Status word write enable |
| stat_wdata | input | 9 | Status word write data |
| int_deleg | input | XLEN | Interrupt delegation mask |
| exc_deleg | input | XLEN | Exception delegation mask |
| s_vec | input | XLEN | Supervisor trap vector |
| s_epc_in | input | XLEN | Saved supervisor exception PC |
| m_epc_in | input | XLEN | Saved machine exception PC |
| done | output | 1 | Entry or legal return committed |
| next_pc | output | XLEN | Handler or return PC, valid with `done` |
| ret_fault | output | 1 | Return refused at privilege U |
| s_ctx_we | output | 1 | Write supervisor cause and exception PC |
| m_ctx_we | output | 1 | Write machine cause and exception PC |
| s_bad_we | output | 1 | Write supervisor bad address |
| m_bad_we | output | 1 | Write machine bad address |
| cause_wdata | output | XLEN | Cause value for the strobed register |
| epc_wdata | output | XLEN | Exception PC for the strobed register |
| bad_wdata | output | XLEN | Bad address for the strobed register |
| cur_priv | output | 2 | Current privilege level |
| status | output | 9 | Status word (layout in R10) |

## Verification
The routing decision is exercised from all three privilege levels. The tests cover exceptions and interrupts with the matching delegation bit set and clear, and a code of 40 against a fully set mask. Together these separate the privilege term, the mask selection by the cause's top bit, and the code range limit. Returns are chained after entries so that the stacked previous-privilege field takes the values U, S and M. This shows whether the enable bit is restored into the mode that was stacked or into the current one. Colliding trap/return/write requests and an illegal m_pp write check the priority order. A long stretch of mixed random requests is then compared on every clock against a behavioural model of the privilege and status stack.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;
    localparam int STAT_W = 9;

    typedef struct packed {
        logic [1:0] m_pp;
        logic       s_pp;
        logic       m_pie;
        logic       s_pie;
        logic       u_pie;
        logic       m_ie;
        logic       s_ie;
        logic       u_ie;
    } stat_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ENTER_S = 3'd1,
        ST_ENTER_M = 3'd2,
        ST_LEAVE   = 3'd3,
        ST_REFUSE  = 3'd4
    } op_state_t;
endpackage

// File: rtl/trap_route.sv
module trap_route #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause,
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] int_deleg,
    input  logic [XLEN-1:0] exc_deleg,
    output logic            to_super
);
    import trap_pkg::*;

    localparam int CW = $clog2(XLEN);
    localparam logic [XLEN-2:0] CODE_LIMIT = (XLEN-1)'(XLEN);

    logic [XLEN-2:0] code;
    logic            is_irq;
    logic            in_range;
    logic            low_priv;
    logic            sel_bit;

    always_comb begin
        code     = cause[XLEN-2:0];
        is_irq   = cause[XLEN-1];
        in_range = code < CODE_LIMIT;
        low_priv = (priv == PRIV_U) || (priv == PRIV_S);
        sel_bit  = is_irq ? int_deleg[code[CW-1:0]] : exc_deleg[code[CW-1:0]];
        to_super = low_priv && in_range && sel_bit;
    end
endmodule

// File: rtl/trap_status.sv
module trap_status (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 do_enter_s,
    input  logic                 do_enter_m,
    input  logic                 do_leave,
    input  logic                 do_write,
    input  trap_pkg::stat_t      wdata,
    output logic [1:0]           priv_q,
    output trap_pkg::stat_t      stat_q
);
    import trap_pkg::*;

    stat_t      stat_d;
    logic [1:0] priv_d;
    logic       cur_ie;
    logic [1:0] back_to;

    function automatic stat_t put_ie(input stat_t s, input logic [1:0] p, input logic v);
        stat_t r;
        r = s;
        case (p)
            PRIV_U:  r.u_ie = v;
            PRIV_S:  r.s_ie = v;
            PRIV_M:  r.m_ie = v;
            default: r = s;
        endcase
        return r;
    endfunction

    always_comb begin
        case (priv_q)
            PRIV_U:  cur_ie = stat_q.u_ie;
            PRIV_S:  cur_ie = stat_q.s_ie;
            default: cur_ie = stat_q.m_ie;
        endcase
    end

    always_comb begin
        stat_d  = stat_q;
        priv_d  = priv_q;
        back_to = PRIV_U;
        if (do_enter_s) begin
            stat_d.s_pie = cur_ie;
            stat_d.s_pp  = (priv_q == PRIV_S);
            stat_d.s_ie  = 1'b0;
            priv_d       = PRIV_S;
        end else if (do_enter_m) begin
            stat_d.m_pie = cur_ie;
            stat_d.m_pp  = priv_q;
            stat_d.m_ie  = 1'b0;
            priv_d       = PRIV_M;
        end else if (do_leave) begin
            if (priv_q == PRIV_S) begin
                back_to      = stat_q.s_pp ? PRIV_S : PRIV_U;
                stat_d       = put_ie(stat_d, back_to, stat_q.s_pie);
                stat_d.s_pie = 1'b0;
                stat_d.s_pp  = 1'b0;
            end else begin
                back_to      = stat_q.m_pp;
                stat_d       = put_ie(stat_d, back_to, stat_q.m_pie);
                stat_d.m_pie = 1'b0;
                stat_d.m_pp  = PRIV_U;
            end
            priv_d = back_to;
        end else if (do_write) begin
            stat_d = wdata;
            if (wdata.m_pp == 2'd2) begin
                stat_d.m_pp = stat_q.m_pp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            priv_q <= PRIV_M;
        end else begin
            stat_q <= stat_d;
            priv_q <= priv_d;
        end
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] M_VEC_BASE = 'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic            ret_req,
    input  logic            to_super,
    input  logic [1:0]      priv_q,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_epc,
    input  logic            trap_has_bad,
    input  logic [XLEN-1:0] trap_bad,
    input  logic [XLEN-1:0] s_vec,
    input  logic [XLEN-1:0] s_epc_in,
    input  logic [XLEN-1:0] m_epc_in,
    output logic            go_enter_s,
    output logic            go_enter_m,
    output logic            go_leave,
    output logic            done,
    output logic [XLEN-1:0] next_pc,
    output logic            ret_fault,
    output logic            s_ctx_we,
    output logic            m_ctx_we,
    output logic            s_bad_we,
    output logic            m_bad_we,
    output logic [XLEN-1:0] cause_wdata,
    output logic [XLEN-1:0] epc_wdata,
    output logic [XLEN-1:0] bad_wdata
);
    import trap_pkg::*;

    op_state_t       state_q, state_d;
    logic [XLEN-1:0] pc_q, pc_d;
    logic [XLEN-1:0] cause_q, epc_q, bad_q;
    logic            has_bad_q;
    logic [XLEN-1:0] m_target;

    // next state: take_s / take_m / resume / deny / rest
    always_comb begin
        m_target = M_VEC_BASE + XLEN'({priv_q, 6'b0});
        state_d  = ST_IDLE;
        pc_d     = pc_q;
        if (trap_req) begin
            state_d = to_super ? ST_ENTER_S : ST_ENTER_M;
            pc_d    = to_super ? s_vec : m_target;
        end else if (ret_req) begin
            if (priv_q == PRIV_U) begin
                state_d = ST_REFUSE;
            end else begin
                state_d = ST_LEAVE;
                pc_d    = (priv_q == PRIV_S) ? s_epc_in : m_epc_in;
            end
        end
        go_enter_s = (state_d == ST_ENTER_S);
        go_enter_m = (state_d == ST_ENTER_M);
        go_leave   = (state_d == ST_LEAVE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pc_q      <= '0;
            cause_q   <= '0;
            epc_q     <= '0;
            bad_q     <= '0;
            has_bad_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            if (trap_req) begin
                cause_q   <= trap_cause;
                epc_q     <= trap_epc;
                bad_q     <= trap_bad;
                has_bad_q <= trap_has_bad;
            end
        end
    end

    // outputs
    always_comb begin
        done        = 1'b0;
        ret_fault   = 1'b0;
        s_ctx_we    = 1'b0;
        m_ctx_we    = 1'b0;
        s_bad_we    = 1'b0;
        m_bad_we    = 1'b0;
        next_pc     = pc_q;
        cause_wdata = cause_q;
        epc_wdata   = epc_q;
        bad_wdata   = bad_q;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ENTER_S: begin
                done     = 1'b1;
                s_ctx_we = 1'b1;
                s_bad_we = has_bad_q;
            end
            ST_ENTER_M: begin
                done     = 1'b1;
                m_ctx_we = 1'b1;
                m_bad_we = has_bad_q;
            end
            ST_LEAVE: begin
                done = 1'b1;
            end
            ST_REFUSE: begin
                ret_fault = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] M_VEC_BASE = 'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_epc,
    input  logic            trap_has_bad,
    input  logic [XLEN-1:0] trap_bad,
    input  logic            ret_req,
    input  logic            stat_we,
    input  logic [8:0]      stat_wdata,
    input  logic [XLEN-1:0] int_deleg,
    input  logic [XLEN-1:0] exc_deleg,
    input  logic [XLEN-1:0] s_vec,
    input  logic [XLEN-1:0] s_epc_in,
    input  logic [XLEN-1:0] m_epc_in,
    output logic            done,
    output logic [XLEN-1:0] next_pc,
    output logic            ret_fault,
    output logic            s_ctx_we,
    output logic            m_ctx_we,
    output logic            s_bad_we,
    output logic            m_bad_we,
    output logic [XLEN-1:0] cause_wdata,
    output logic [XLEN-1:0] epc_wdata,
    output logic [XLEN-1:0] bad_wdata,
    output logic [1:0]      cur_priv,
    output logic [8:0]      status
);
    import trap_pkg::*;

    logic  to_super;
    logic  go_enter_s, go_enter_m, go_leave;
    logic  do_write;
    stat_t stat_q;
    stat_t wr_word;

    assign do_write = stat_we && !trap_req && !ret_req;
    assign wr_word  = stat_t'(stat_wdata);
    assign status   = stat_q;

    trap_route #(.XLEN(XLEN)) u_route (
        .cause     (trap_cause),
        .priv      (cur_priv),
        .int_deleg (int_deleg),
        .exc_deleg (exc_deleg),
        .to_super  (to_super)
    );

    trap_seq #(.XLEN(XLEN), .M_VEC_BASE(M_VEC_BASE)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_req     (trap_req),
        .ret_req      (ret_req),
        .to_super     (to_super),
        .priv_q       (cur_priv),
        .trap_cause   (trap_cause),
        .trap_epc     (trap_epc),
        .trap_has_bad (trap_has_bad),
        .trap_bad     (trap_bad),
        .s_vec        (s_vec),
        .s_epc_in     (s_epc_in),
        .m_epc_in     (m_epc_in),
        .go_enter_s   (go_enter_s),
        .go_enter_m   (go_enter_m),
        .go_leave     (go_leave),
        .done         (done),
        .next_pc      (next_pc),
        .ret_fault    (ret_fault),
        .s_ctx_we     (s_ctx_we),
        .m_ctx_we     (m_ctx_we),
        .s_bad_we     (s_bad_we),
        .m_bad_we     (m_bad_we),
        .cause_wdata  (cause_wdata),
        .epc_wdata    (epc_wdata),
        .bad_wdata    (bad_wdata)
    );

    trap_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_enter_s (go_enter_s),
        .do_enter_m (go_enter_m),
        .do_leave   (go_leave),
        .do_write   (do_write),
        .wdata      (wr_word),
        .priv_q     (cur_priv),
        .stat_q     (stat_q)
    );
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trap_req,
    input logic       ret_req,
    input logic       done,
    input logic       ret_fault,
    input logic       s_ctx_we,
    input logic       m_ctx_we,
    input logic       s_bad_we,
    input logic       m_bad_we,
    input logic [1:0] cur_priv,
    input logic       s_ie,
    input logic       m_ie
);
    a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_ctx_we, m_ctx_we, ret_fault}));
    a_r8_entry_is_done: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ctx_we || m_ctx_we) |-> done);
    a_r8_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(trap_req || ret_req));
    a_r3_sbad_with_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        s_bad_we |-> s_ctx_we);
    a_r4_mbad_with_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        m_bad_we |-> m_ctx_we);
    a_r3_s_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
        s_ctx_we |-> (cur_priv == 2'd1) && !s_ie);
    a_r4_m_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
        m_ctx_we |-> (cur_priv == 2'd3) && !m_ie);
    a_r2_no_s_from_m: assert property (@(posedge clk) disable iff (!rst_n)
        s_ctx_we |-> $past(cur_priv) != 2'd3);
    a_r7_fault_in_user: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fault |-> (cur_priv == 2'd0) && !done);
    a_r9_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && ret_req) |=> (s_ctx_we || m_ctx_we) && !ret_fault);
endmodule

bind trap_unit trap_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req),
    .ret_req   (ret_req),
    .done      (done),
    .ret_fault (ret_fault),
    .s_ctx_we  (s_ctx_we),
    .m_ctx_we  (m_ctx_we),
    .s_bad_we  (s_bad_we),
    .m_bad_we  (m_bad_we),
    .cur_priv  (cur_priv),
    .s_ie      (status[1]),
    .m_ie      (status[2])
);

// File: tb/sim_trap_unit.sv
module sim_trap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int XL = 32;
    localparam logic [31:0] BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 0, trap_has_bad = 0, ret_req = 0, stat_we = 0;
    logic [31:0] trap_cause = 0, trap_epc = 0, trap_bad = 0;
    logic [8:0]  stat_wdata = 0;
    logic [31:0] int_deleg = 32'h22, exc_deleg = 32'h100;
    logic [31:0] s_vec = 32'h8000_0200, s_epc_in = 32'h4000_1000, m_epc_in = 32'h4000_2000;
    logic        done, ret_fault, s_ctx_we, m_ctx_we, s_bad_we, m_bad_we;
    logic [31:0] next_pc, cause_wdata, epc_wdata, bad_wdata;
    logic [1:0]  cur_priv;
    logic [8:0]  status;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int   m_priv;
    logic ie[4];
    logic pie[4];
    logic m_spp;
    int   m_mpp;
    logic e_done, e_fault, e_sctx, e_mctx, e_sbad, e_mbad;
    logic [31:0] e_pc, e_cause, e_epc, e_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_unit #(.XLEN(XL), .M_VEC_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
        .trap_epc(trap_epc), .trap_has_bad(trap_has_bad), .trap_bad(trap_bad),
        .ret_req(ret_req), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .int_deleg(int_deleg), .exc_deleg(exc_deleg), .s_vec(s_vec),
        .s_epc_in(s_epc_in), .m_epc_in(m_epc_in), .done(done), .next_pc(next_pc),
        .ret_fault(ret_fault), .s_ctx_we(s_ctx_we), .m_ctx_we(m_ctx_we),
        .s_bad_we(s_bad_we), .m_bad_we(m_bad_we), .cause_wdata(cause_wdata),
        .epc_wdata(epc_wdata), .bad_wdata(bad_wdata), .cur_priv(cur_priv),
        .status(status)
    );

    function automatic logic [8:0] pack_stat();
        return {2'(m_mpp), m_spp, pie[3], pie[1], pie[0], ie[3], ie[1], ie[0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_priv = 3; m_spp = 0; m_mpp = 0;
        for (int i = 0; i < 4; i++) begin ie[i] = 0; pie[i] = 0; end
        {e_done, e_fault, e_sctx, e_mctx, e_sbad, e_mbad} = '0;
    endtask

    task automatic model_step();
        int  code, pp;
        logic dl, cie;
        {e_done, e_fault, e_sctx, e_mctx, e_sbad, e_mbad} = '0;
        if (trap_req) begin
            code = int'(trap_cause[30:0]);
            dl = trap_cause[31] ? int_deleg[code % 32] : exc_deleg[code % 32];
            cie = ie[m_priv];
            e_cause = trap_cause; e_epc = trap_epc; e_bad = trap_bad; e_done = 1;
            if (m_priv <= 1 && code < 32 && dl) begin
                e_pc = s_vec; e_sctx = 1; e_sbad = trap_has_bad;
                pie[1] = cie; m_spp = (m_priv == 1); ie[1] = 0; m_priv = 1;
            end else begin
                e_pc = BASE + 32'(64 * m_priv); e_mctx = 1; e_mbad = trap_has_bad;
                pie[3] = cie; m_mpp = m_priv; ie[3] = 0; m_priv = 3;
            end
        end else if (ret_req) begin
            if (m_priv == 0) begin
                e_fault = 1;
            end else if (m_priv == 1) begin
                e_done = 1; e_pc = s_epc_in; pp = m_spp ? 1 : 0;
                ie[pp] = pie[1]; pie[1] = 0; m_priv = pp; m_spp = 0;
            end else begin
                e_done = 1; e_pc = m_epc_in; pp = m_mpp;
                ie[pp] = pie[3]; pie[3] = 0; m_priv = pp; m_mpp = 0;
            end
        end else if (stat_we) begin
            ie[0] = stat_wdata[0]; ie[1] = stat_wdata[1]; ie[3] = stat_wdata[2];
            pie[0] = stat_wdata[3]; pie[1] = stat_wdata[4]; pie[3] = stat_wdata[5];
            m_spp = stat_wdata[6];
            if (stat_wdata[8:7] != 2'd2) m_mpp = int'(stat_wdata[8:7]);
        end
    endtask

    task automatic cycle(input string req);
        model_step();
        @(posedge clk);
        #1;
        chk(req, "done", 32'(done), 32'(e_done));
        chk(req, "ret_fault", 32'(ret_fault), 32'(e_fault));
        chk(req, "s_ctx_we", 32'(s_ctx_we), 32'(e_sctx));
        chk(req, "m_ctx_we", 32'(m_ctx_we), 32'(e_mctx));
        chk(req, "s_bad_we", 32'(s_bad_we), 32'(e_sbad));
        chk(req, "m_bad_we", 32'(m_bad_we), 32'(e_mbad));
        chk(req, "priv", 32'(cur_priv), 32'(m_priv));
        chk(req, "status", 32'(status), 32'(pack_stat()));
        if (e_done) chk(req, "next_pc", next_pc, e_pc);
        if (e_sctx || e_mctx) begin
            chk(req, "cause", cause_wdata, e_cause);
            chk(req, "epc", epc_wdata, e_epc);
        end
        if (e_sbad || e_mbad) chk(req, "bad", bad_wdata, e_bad);
        trap_req = 0; ret_req = 0; stat_we = 0; trap_has_bad = 0;
    endtask

    task automatic do_trap(input logic [31:0] c, input logic hb, input string req);
        trap_req = 1; trap_cause = c; trap_epc = c ^ 32'h1234_5670;
        trap_has_bad = hb; trap_bad = ~c;
        cycle(req);
    endtask

    task automatic do_ret(input string req);
        ret_req = 1;
        cycle(req);
    endtask

    task automatic do_write(input logic [8:0] v, input string req);
        stat_we = 1; stat_wdata = v;
        cycle(req);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        chk("R1", "priv", 32'(cur_priv), 32'd3);
        chk("R1", "status", 32'(status), 32'd0);
        chk("R1", "pulses", 32'({done, ret_fault, s_ctx_we, m_ctx_we, s_bad_we, m_bad_we}), 32'd0);
        cycle("R1");

        do_write(9'h004, "R10");                 // m_ie = 1
        do_trap(32'd8, 1'b1, "R2");              // delegated code, but in M -> machine
        do_ret("R6");                            // back to M, m_ie restored
        do_write(9'h021, "R10");                 // m_pie=1, u_ie=1, m_pp=U
        do_ret("R6");                            // M -> U
        do_ret("R7");                            // refused in U
        cycle("R7");
        do_trap(32'd8, 1'b1, "R3");              // U -> S via exc_deleg bit 8
        do_trap(32'h8000_0007, 1'b0, "R4");      // irq 7 not delegated -> M from S
        do_ret("R6");                            // M -> S
        exc_deleg = 32'hFFFF_FFFF;
        do_trap(32'd40, 1'b1, "R2");             // code out of range -> M
        do_ret("R6");
        exc_deleg = 32'h100;
        do_trap(32'h8000_0005, 1'b0, "R2");      // delegated irq from S -> S
        do_ret("R5");                            // S -> S
        do_ret("R5");                            // s_pp now U -> U
        trap_req = 1; trap_cause = 32'd2; ret_req = 1;
        cycle("R9");                             // trap wins
        do_write(9'h17F, "R10");                 // m_pp = 2 rejected
        trap_req = 1; trap_cause = 32'd3; stat_we = 1; stat_wdata = 9'h0FF;
        cycle("R10");                            // write ignored with trap
        do_trap(32'd4, 1'b0, "R8");
        do_trap(32'd5, 1'b1, "R8");              // back to back
        cycle("R8");

        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = $urandom_range(0, 9);
            int_deleg = $urandom; exc_deleg = $urandom;
            s_vec = $urandom; s_epc_in = $urandom; m_epc_in = $urandom;
            if (sel < 3) begin
                trap_req = 1; trap_cause = {1'($urandom), 31'($urandom_range(0, 40))};
                trap_epc = $urandom; trap_bad = $urandom; trap_has_bad = 1'($urandom);
            end
            if (sel >= 2 && sel < 6) ret_req = 1;
            if (sel >= 5 && sel < 8) begin
                stat_we = 1; stat_wdata = 9'($urandom);
            end
            cycle("R2");
        end
        finish_run();
    end
endmodule